// File: doc/BRIEF.md
# Operand Bypass and Hazard Control for a Five-Stage Pipeline

This block holds the hazard decisions of an in-order pipeline with five stages: instruction fetch, decode, execute, memory access and write-back. It is purely combinational. It reads the register numbers and the write and load flags that the pipeline registers carry, and from them it drives the bypass selects for both execute-stage ALU operands, the stall controls for a load-use dependency and the flush controls for a taken branch.

A result that is still in flight in the memory or write-back stage is steered straight to the ALU input of a dependent instruction, so no software no-ops are needed. A load is the exception, because its data exists only after the memory stage. When the instruction right behind a load reads the load's destination, the block holds the program counter and the fetch/decode register and puts a no-op into the decode/execute register, which creates a one-cycle bubble. Fetch always assumes that a branch is not taken. Branches resolve in execute, so when one is taken the two younger instructions, held in fetch/decode and decode/execute, are squashed.

Top module: `hz_unit`

## Requirements
- R1: When the memory stage writes a nonzero register equal to an execute-stage source, that operand's select is 2'b10 (memory-stage result). `fwd_a` serves the first source and `fwd_b` the second.
- R2: When only the write-back stage writes a nonzero register equal to an execute-stage source, that operand's select is 2'b01 (write-back result).
- R3: When the memory and write-back stages both match the same source, the memory-stage result wins (2'b10).
- R4: When no enabled producer matches, the select is 2'b00 (register file). A producer whose write enable is low never matches, and 2'b11 is never produced.
- R5: Register 0 is never forwarded. A source of 0 always gets 2'b00, even when a producer names register 0 with its write enabled.
- R6: When the execute stage holds a load whose destination is nonzero and equals either decode-stage source, `pc_hold`, `ifid_hold` and `idex_bubble` are all 1.
- R7: A load whose destination is register 0 does not stall, and a producer in execute that is not a load does not stall.
- R8: When `ex_branch_taken` is 1, `ifid_flush` and `idex_flush` are both 1, and the three stall outputs are 0 even if a load-use match is present.
- R9: With no dependency and no taken branch, all stall and flush outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | AW | First source register of the instruction in decode |
| id_rs2 | input | AW | Second source register of the instruction in decode |
| ex_rs1 | input | AW | First source register of the instruction in execute |
| ex_rs2 | input | AW | Second source register of the instruction in execute |
| ex_rd | input | AW | Destination register of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute is a load |
| ex_branch_taken | input | 1 | Branch in execute resolved taken |
| mem_rd | input | AW | Destination register in the memory stage |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | AW | Destination register in the write-back stage |
| wb_wen | input | 1 | Write-back instruction writes a register |
| fwd_a | output | 2 | Bypass select for ALU operand A (00 file, 01 write-back, 10 memory) |
| fwd_b | output | 2 | Bypass select for ALU operand B (same encoding) |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |
| ifid_flush | output | 1 | Squash the fetch/decode register |
| idex_flush | output | 1 | Squash the decode/execute register |

## Verification
The hardest situations to reach are those where several rules meet on one cycle. Examples are a load-use match together with a taken branch, both producer stages naming the same source, and register 0 named by enabled producers and by a load. Directed tasks set up each of these collisions explicitly. A sweep then draws every register number from a two-bit range, so that equal register numbers, zero registers and write-enable combinations occur in every mix.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel #(
  parameter int AW = 5
) (
  input  logic [AW-1:0]   src,
  input  logic [AW-1:0]   mem_rd,
  input  logic            mem_wen,
  input  logic [AW-1:0]   wb_rd,
  input  logic            wb_wen,
  output hz_pkg::fwd_sel_e sel
);
  import hz_pkg::*;

  function automatic logic producer_hits(input logic wen,
                                         input logic [AW-1:0] rd,
                                         input logic [AW-1:0] s);
    return wen && (rd != '0) && (rd == s);
  endfunction

  logic mem_hit;
  logic wb_hit;
  assign mem_hit = producer_hits(mem_wen, mem_rd, src);
  assign wb_hit  = producer_hits(wb_wen, wb_rd, src);

  always_comb begin
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  always_comb begin
    if (!$isunknown({src, mem_rd, mem_wen, wb_rd, wb_wen})) begin
      // R5
      zero_src_chk: assert (src != '0 || sel == FWD_RF);
      // R4
      no_producer_chk: assert (mem_wen || wb_wen || sel == FWD_RF);
      // R4
      legal_sel_chk: assert (sel != 2'b11);
    end
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_is_load,
  output logic          hazard
);
  logic rs1_dep;
  logic rs2_dep;
  logic dest_live;

  assign dest_live = ex_is_load && (ex_rd != '0);
  assign rs1_dep   = dest_live && (ex_rd == id_rs1);
  assign rs2_dep   = dest_live && (ex_rd == id_rs2);
  assign hazard    = rs1_dep || rs2_dep;

  always_comb begin
    if (!$isunknown({id_rs1, id_rs2, ex_rd, ex_is_load})) begin
      // R7
      zero_dest_chk: assert (ex_rd != '0 || !hazard);
      // R7
      non_load_chk: assert (ex_is_load || !hazard);
    end
  end
endmodule

// File: rtl/hz_flush.sv
module hz_flush (
  input  logic load_hazard,
  input  logic branch_taken,
  output logic pc_hold,
  output logic ifid_hold,
  output logic idex_bubble,
  output logic ifid_flush,
  output logic idex_flush
);
  logic stall;
  assign stall       = load_hazard && !branch_taken;
  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;
  assign ifid_flush  = branch_taken;
  assign idex_flush  = branch_taken;

  always_comb begin
    if (!$isunknown({load_hazard, branch_taken})) begin
      // R8
      flush_beats_stall_chk: assert (!(ifid_flush && (pc_hold || ifid_hold || idex_bubble)));
      // R6
      stall_group_chk: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble);
      // R9
      quiet_chk: assert (load_hazard || branch_taken || !(pc_hold || ifid_flush || idex_flush));
    end
  end
endmodule

// File: rtl/hz_unit.sv
module hz_unit #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_is_load,
  input  logic          ex_branch_taken,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          idex_bubble,
  output logic          ifid_flush,
  output logic          idex_flush
);
  localparam int NSRC = 2;

  logic [AW-1:0]    ex_src [NSRC];
  hz_pkg::fwd_sel_e op_sel [NSRC];
  logic             load_hazard;

  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;

  for (genvar g = 0; g < NSRC; g++) begin : g_op
    hz_fwd_sel #(.AW(AW)) u_sel (
      .src     (ex_src[g]),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .sel     (op_sel[g])
    );
  end

  assign fwd_a = op_sel[0];
  assign fwd_b = op_sel[1];

  hz_load_use #(.AW(AW)) u_lu (
    .id_rs1     (id_rs1),
    .id_rs2     (id_rs2),
    .ex_rd      (ex_rd),
    .ex_is_load (ex_is_load),
    .hazard     (load_hazard)
  );

  hz_flush u_fl (
    .load_hazard  (load_hazard),
    .branch_taken (ex_branch_taken),
    .pc_hold      (pc_hold),
    .ifid_hold    (ifid_hold),
    .idex_bubble  (idex_bubble),
    .ifid_flush   (ifid_flush),
    .idex_flush   (idex_flush)
  );

  always_comb begin
    if (!$isunknown({mem_rd, mem_wen, wb_rd, wb_wen, ex_rs1})) begin
      // R3
      mem_over_wb_chk: assert (!(mem_wen && wb_wen && mem_rd == wb_rd && mem_rd == ex_rs1
                                 && ex_rs1 != '0) || fwd_a == 2'b10);
    end
  end
endmodule

// File: tb/hz_unit_test.sv
module hz_unit_test;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_is_load, ex_branch_taken, mem_wen, wb_wen;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush;

  int n_checks = 0;
  int n_fail   = 0;

  hz_unit #(.AW(AW)) uut (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_is_load(ex_is_load), .ex_branch_taken(ex_branch_taken),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
    .idex_bubble(idex_bubble), .ifid_flush(ifid_flush), .idex_flush(idex_flush)
  );

  // Expected bypass choice, from R1..R5
  function automatic logic [1:0] want_sel(input logic [AW-1:0] s);
    logic [1:0] r;
    r = 2'b00;
    if (s != 0) begin
      if (wb_wen && wb_rd == s)   r = 2'b01;
      if (mem_wen && mem_rd == s) r = 2'b10;
    end
    return r;
  endfunction

  // Expected {pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush}, from R6..R9
  function automatic logic [4:0] want_ctl();
    logic dep;
    dep = ex_is_load && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
    if (ex_branch_taken) return 5'b00011;
    return dep ? 5'b11100 : 5'b00000;
  endfunction

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [8:0] got, exp;
    got = {fwd_a, fwd_b, pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush};
    exp = {want_sel(ex_rs1), want_sel(ex_rs2), want_ctl()};
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic clear();
    id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
    mem_rd = 0; wb_rd = 0; ex_is_load = 0; ex_branch_taken = 0;
    mem_wen = 0; wb_wen = 0;
  endtask

  task automatic t_idle();
    clear(); ex_rs1 = 3; ex_rs2 = 4; id_rs1 = 5; id_rs2 = 6; settle();
    check_all("R9 idle");
    if (fwd_a !== 2'b00 || pc_hold !== 1'b0) begin
      n_fail++; $display("FAIL R9 idle literal: actual %b/%b expected 00/0", fwd_a, pc_hold);
    end
    n_checks++;
  endtask

  task automatic t_mem_fwd();
    clear(); ex_rs1 = 7; ex_rs2 = 9; mem_rd = 7; mem_wen = 1; settle();
    check_all("R1 mem to A");
    if (fwd_a !== 2'b10) begin n_fail++; $display("FAIL R1: actual %b expected 10", fwd_a); end
    n_checks++;
    mem_rd = 9; settle(); check_all("R1 mem to B");
  endtask

  task automatic t_wb_fwd();
    clear(); ex_rs1 = 12; ex_rs2 = 12; wb_rd = 12; wb_wen = 1; settle();
    check_all("R2 wb to both");
    if (fwd_b !== 2'b01) begin n_fail++; $display("FAIL R2: actual %b expected 01", fwd_b); end
    n_checks++;
  endtask

  task automatic t_prio();
    clear(); ex_rs1 = 5; ex_rs2 = 6; mem_rd = 5; wb_rd = 5; mem_wen = 1; wb_wen = 1; settle();
    check_all("R3 mem over wb");
    if (fwd_a !== 2'b10) begin n_fail++; $display("FAIL R3: actual %b expected 10", fwd_a); end
    n_checks++;
  endtask

  task automatic t_wen_off();
    clear(); ex_rs1 = 8; ex_rs2 = 8; mem_rd = 8; wb_rd = 8; settle();
    check_all("R4 writes disabled");
  endtask

  task automatic t_zero_reg();
    clear(); mem_wen = 1; wb_wen = 1; settle();
    check_all("R5 zero register");
    if (fwd_a !== 2'b00 || fwd_b !== 2'b00) begin
      n_fail++; $display("FAIL R5: actual %b%b expected 0000", fwd_a, fwd_b);
    end
    n_checks++;
  endtask

  task automatic t_load_use();
    clear(); ex_is_load = 1; ex_rd = 10; id_rs1 = 10; id_rs2 = 3; settle();
    check_all("R6 load-use rs1");
    if (idex_bubble !== 1'b1) begin n_fail++; $display("FAIL R6: actual %b expected 1", idex_bubble); end
    n_checks++;
    id_rs1 = 2; id_rs2 = 10; settle(); check_all("R6 load-use rs2");
  endtask

  task automatic t_no_stall();
    clear(); ex_is_load = 1; ex_rd = 0; settle();
    check_all("R7 load to zero");
    ex_is_load = 0; ex_rd = 11; id_rs1 = 11; settle();
    check_all("R7 alu producer");
  endtask

  task automatic t_branch();
    clear(); ex_branch_taken = 1; settle();
    check_all("R8 taken branch");
    ex_is_load = 1; ex_rd = 4; id_rs1 = 4; settle();
    check_all("R8 branch with load-use");
    if (pc_hold !== 1'b0 || idex_flush !== 1'b1) begin
      n_fail++; $display("FAIL R8: actual %b%b expected 01", pc_hold, idex_flush);
    end
    n_checks++;
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 4096; i++) begin
      logic [11:0] v;
      v = i[11:0];
      ex_rs1 = {3'b0, v[1:0]};  ex_rs2 = {3'b0, v[3:2]};
      mem_rd = {3'b0, v[5:4]};  wb_rd  = {3'b0, v[7:6]};
      mem_wen = v[8]; wb_wen = v[9]; ex_is_load = v[10]; ex_branch_taken = v[11];
      ex_rd = {3'b0, v[5:4] ^ v[1:0]}; id_rs1 = {3'b0, v[7:6]}; id_rs2 = {3'b0, v[3:2]};
      settle();
      check_all("R1 R2 R3 R4 R5 R6 R7 R8 R9 sweep");
    end
  endtask

  initial begin
    clear();
    fork
      begin
        t_idle(); t_mem_fwd(); t_wb_fwd(); t_prio(); t_wen_off(); t_zero_reg();
        t_load_use(); t_no_stall(); t_branch(); t_sweep();
      end
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule